// File: doc/BRIEF.md
# Synthesizer register load sequencer

This block loads a fractional-N frequency synthesizer over a three-wire serial link: a serial clock, a data line and a latch enable. The host places six 32-bit register images on a parallel bus and pulses `start`. The block copies all six images into internal storage and then sends them from the highest-numbered register down to register 0. Register 0 holds the frequency setting, so it is always the last word committed.

Every word goes out most significant bit first. The data line changes while the serial clock is low, and the device samples it on the rising edge. After the 32nd bit a latch pulse commits the word. A fixed idle gap follows before the next word begins. After the last word and its gap, the block watches a lock-detect input through a two-flop synchronizer. It then ends the sequence with a one-cycle `done` pulse and one of two outcomes: locked, or timed out.

All timing is set in system clock cycles by parameters: the half bit period, the latch width, the gap between words and the lock timeout. The host must put each register's address in the low three bits of its word, because the words are sent unchanged.

Top module: `synthRegLoader`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `serClk`, `serData`, `serLatch`, `busy`, `done`, `locked` and `timedOut` are all low.
- R2: Each word is sent as exactly 32 rising edges of `serClk`, most significant bit first. `serData` is valid at each rising edge. Within a word, `serClk` stays high for `BIT_HALF` cycles and low for `BIT_HALF` cycles between bits.
- R3: Input slice `wordsIn[32k+31:32k]` is register k. The words are sent unchanged in the order k = 5, 4, 3, 2, 1, 0, so the low three bits of the k-th word sent carry the address 5 down to 0.
- R4: After each word's 32nd bit, `serLatch` is high for exactly `LATCH_CYC` cycles, and `serClk` is low for that whole time.
- R5: The first rising `serClk` edge of the next word comes exactly `GAP_CYC + BIT_HALF` cycles after `serLatch` falls.
- R6: `busy` goes high the cycle after `start` is accepted and is low when `done` is high. A `start` pulse while `busy` is high is ignored: exactly six words and one `done` pulse result.
- R7: All six words are captured when the sequence starts. Changes to `wordsIn` after that have no effect on the words sent.
- R8: If the synchronized lock-detect input is high during the lock wait, the sequence ends with `done` and `locked` high and `timedOut` low.
- R9: If lock-detect stays low, `done` and `timedOut` rise exactly `GAP_CYC + LOCK_TMO` cycles after the final latch pulse falls, and `locked` stays low.
- R10: `done` is high for a single cycle. `locked` and `timedOut` keep their value after the sequence and are cleared when the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load sequence |
| wordsIn | input | NUM_WORDS*WORD_W | Register images; slice k is register k |
| lockDetect | input | 1 | Asynchronous lock indication from the synthesizer |
| serClk | output | 1 | Serial clock, idles low |
| serData | output | 1 | Serial data, sampled on the rising edge of serClk |
| serLatch | output | 1 | Latch enable pulse after each word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| locked | output | 1 | Last sequence ended with lock seen |
| timedOut | output | 1 | Last sequence ended without lock |

## Verification
Each output is registered once after the control state. A state entered at one edge therefore shows on the serial pins one edge later, and all pin-to-pin intervals are exact cycle counts: the high and low widths of the serial clock, the latch width, and the gap from latch fall to the next rising clock edge. The bench samples every output on the falling clock edge and tags each change with the count of rising edges so far. It compares the differences between these tags with the parameter formulas and does not try to predict absolute cycles. A timeout outcome is checked as an exact distance from the last latch fall to `done`. A lock outcome is checked through the flags, which are read several cycles after `done` to confirm they hold.

// File: rtl/synthLoadPkg.sv
package synthLoadPkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LO    = 3'd1,
    S_HI    = 3'd2,
    S_LATCH = 3'd3,
    S_GAP   = 3'd4,
    S_LOCK  = 3'd5
  } seqState_e;

  typedef struct packed {
    logic capture;   // copy all words, preload the first one
    logic loadWord;  // load the next captured word into the shifter
    logic shiftBit;  // advance the shifter by one bit
    logic clkLvl;    // serial clock level for the next cycle
    logic latchLvl;  // latch enable level for the next cycle
  } seqStrb_t;

endpackage

// File: rtl/lockSyncChain.sv
module lockSyncChain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] syncReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[STAGES-2:0], asyncIn};
  end

  assign syncOut = syncReg[STAGES-1];

endmodule

// File: rtl/synthSeqCtrl.sv
module synthSeqCtrl
  import synthLoadPkg::*;
#(
  parameter int NUM_WORDS = 6,
  parameter int WORD_W    = 32,
  parameter int BIT_HALF  = 2,
  parameter int LATCH_CYC = 6,
  parameter int GAP_CYC   = 40,
  parameter int LOCK_TMO  = 100,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             lockSync,
  output seqStrb_t         strb,
  output logic [IDX_W-1:0] wordSel,
  output logic             busy,
  output logic             done,
  output logic             locked,
  output logic             timedOut
);

  localparam int BIT_W   = $clog2(WORD_W);
  localparam int MAX_A   = (BIT_HALF > LATCH_CYC) ? BIT_HALF : LATCH_CYC;
  localparam int MAX_B   = (GAP_CYC > MAX_A) ? GAP_CYC : MAX_A;
  localparam int MAX_CNT = (LOCK_TMO > MAX_B) ? LOCK_TMO : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(BIT_HALF - 1);
  localparam logic [CNT_W-1:0] LATCH_LAST = CNT_W'(LATCH_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_END    = CNT_W'(LOCK_TMO);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NUM_WORDS - 1);

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic [IDX_W-1:0] wordIdx;

  logic loLast, hiLast, latchLast, gapLast, lockEnd;

  assign loLast    = (state == S_LO)    && (cnt == HALF_LAST);
  assign hiLast    = (state == S_HI)    && (cnt == HALF_LAST);
  assign latchLast = (state == S_LATCH) && (cnt == LATCH_LAST);
  assign gapLast   = (state == S_GAP)   && (cnt == GAP_LAST);
  assign lockEnd   = (state == S_LOCK)  && (lockSync || (cnt == TMO_END));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitCnt   <= '0;
      wordIdx  <= '0;
      done     <= 1'b0;
      locked   <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_LO;
            cnt      <= '0;
            bitCnt   <= BIT_LAST;
            wordIdx  <= IDX_LAST;
            locked   <= 1'b0;
            timedOut <= 1'b0;
          end
        end
        S_LO: begin
          if (loLast) begin
            state <= S_HI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_HI: begin
          if (hiLast) begin
            cnt <= '0;
            if (bitCnt == '0) begin
              state <= S_LATCH;
            end else begin
              bitCnt <= bitCnt - BIT_W'(1);
              state  <= S_LO;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_LATCH: begin
          if (latchLast) begin
            state <= S_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_GAP: begin
          if (gapLast) begin
            cnt <= '0;
            if (wordIdx == '0) begin
              state <= S_LOCK;
            end else begin
              wordIdx <= wordIdx - IDX_W'(1);
              bitCnt  <= BIT_LAST;
              state   <= S_LO;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_LOCK: begin
          if (lockEnd) begin
            state    <= S_IDLE;
            cnt      <= '0;
            done     <= 1'b1;
            locked   <= lockSync;
            timedOut <= !lockSync;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.capture  = (state == S_IDLE) && start;
    strb.loadWord = gapLast && (wordIdx != '0);
    strb.shiftBit = hiLast && (bitCnt != '0);
    strb.clkLvl   = (state == S_HI);
    strb.latchLvl = (state == S_LATCH);
  end

  assign wordSel = wordIdx - IDX_W'(1);
  assign busy    = (state != S_IDLE);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(locked && timedOut));

  // R10
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!locked && !timedOut));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/synthSeqData.sv
module synthSeqData
  import synthLoadPkg::*;
#(
  parameter int NUM_WORDS = 6,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_WORDS*WORD_W-1:0] wordsIn,
  input  seqStrb_t                    strb,
  input  logic [IDX_W-1:0]            wordSel,
  output logic                        serClk,
  output logic                        serData,
  output logic                        serLatch
);

  logic [WORD_W-1:0] capWords [NUM_WORDS];
  logic [WORD_W-1:0] shiftReg;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             capWords[k] <= '0;
      else if (strb.capture) capWords[k] <= wordsIn[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.capture) begin
      shiftReg <= wordsIn[(NUM_WORDS-1)*WORD_W +: WORD_W];
    end else if (strb.loadWord) begin
      shiftReg <= capWords[wordSel];
    end else if (strb.shiftBit) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClk   <= 1'b0;
      serData  <= 1'b0;
      serLatch <= 1'b0;
    end else begin
      serClk   <= strb.clkLvl;
      serData  <= shiftReg[WORD_W-1];
      serLatch <= strb.latchLvl;
    end
  end

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    serClk |=> (!serClk || $stable(serData)));

  // R4
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(serLatch && serClk));

endmodule

// File: rtl/synthRegLoader.sv
module synthRegLoader
  import synthLoadPkg::*;
#(
  parameter int NUM_WORDS   = 6,
  parameter int WORD_W      = 32,
  parameter int BIT_HALF    = 2,
  parameter int LATCH_CYC   = 6,
  parameter int GAP_CYC     = 40,
  parameter int LOCK_TMO    = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [NUM_WORDS*WORD_W-1:0] wordsIn,
  input  logic                        lockDetect,
  output logic                        serClk,
  output logic                        serData,
  output logic                        serLatch,
  output logic                        busy,
  output logic                        done,
  output logic                        locked,
  output logic                        timedOut
);

  localparam int IDX_W = $clog2(NUM_WORDS);

  seqStrb_t         strb;
  logic [IDX_W-1:0] wordSel;
  logic             lockSync;

  lockSyncChain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (lockDetect),
    .syncOut (lockSync)
  );

  synthSeqCtrl #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .BIT_HALF  (BIT_HALF),
    .LATCH_CYC (LATCH_CYC),
    .GAP_CYC   (GAP_CYC),
    .LOCK_TMO  (LOCK_TMO)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lockSync (lockSync),
    .strb     (strb),
    .wordSel  (wordSel),
    .busy     (busy),
    .done     (done),
    .locked   (locked),
    .timedOut (timedOut)
  );

  synthSeqData #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .wordsIn  (wordsIn),
    .strb     (strb),
    .wordSel  (wordSel),
    .serClk   (serClk),
    .serData  (serData),
    .serLatch (serLatch)
  );

endmodule

// File: tb/tb_synthRegLoader.sv
`timescale 1ns/1ps
module tb_synthRegLoader;

  localparam int NW    = 6;
  localparam int WW    = 32;
  localparam int HALF  = 2;
  localparam int LATCH = 6;
  localparam int GAP   = 40;
  localparam int TMO   = 100;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NW*WW-1:0] wordsIn = '0;
  logic lockDetect = 1'b0;
  logic serClk, serData, serLatch, busy, done, locked, timedOut;

  always #2.5 clk = ~clk;

  synthRegLoader #(
    .NUM_WORDS(NW), .WORD_W(WW), .BIT_HALF(HALF),
    .LATCH_CYC(LATCH), .GAP_CYC(GAP), .LOCK_TMO(TMO)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .wordsIn(wordsIn),
    .lockDetect(lockDetect), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .busy(busy), .done(done), .locked(locked),
    .timedOut(timedOut)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      nChecks++;
      nFail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  // serial decoder, sampled away from the active edge
  logic [WW-1:0] got [8];
  logic [WW-1:0] shiftW = '0;
  int nGot = 0, bitsIn = 0, riseCyc = 0, fallCyc = 0, latchRise = 0, lastLatchFall = 0;
  int doneCnt = 0, doneCyc = 0;
  bit gapPending = 0, pClk = 0, pLatch = 0, pDone = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (serClk && !pClk) begin
        if (gapPending) chk(cyc - lastLatchFall == GAP + HALF, "R5 gap", cyc - lastLatchFall, GAP + HALF);
        else if (bitsIn > 0) chk(cyc - fallCyc == HALF, "R2 clock low", cyc - fallCyc, HALF);
        gapPending = 0;
        shiftW = {shiftW[WW-2:0], serData};
        bitsIn++;
        riseCyc = cyc;
      end
      if (!serClk && pClk) begin
        chk(cyc - riseCyc == HALF, "R2 clock high", cyc - riseCyc, HALF);
        fallCyc = cyc;
      end
      if (serLatch && !pLatch) begin
        chk(bitsIn == WW, "R2 bit count", bitsIn, WW);
        chk(!serClk, "R4 clock low in latch", serClk, 0);
        if (nGot < 8) got[nGot] = shiftW;
        nGot++;
        bitsIn = 0;
        latchRise = cyc;
      end
      if (!serLatch && pLatch) begin
        chk(cyc - latchRise == LATCH, "R4 latch width", cyc - latchRise, LATCH);
        lastLatchFall = cyc;
        gapPending = 1;
      end
      if (done) begin
        if (pDone) chk(0, "R10 done width", 2, 1);
        doneCnt++;
        doneCyc = cyc;
      end
    end
    pClk = serClk;
    pLatch = serLatch;
    pDone = done;
  end

  function automatic logic [WW-1:0] mkWord(input logic [WW-1:0] body, input int k);
    return {body[WW-1:3], 3'(k)};
  endfunction

  // mode: 0 lock high throughout, 1 lock rises late, 2 never locks
  task automatic runSeq(input logic [WW-1:0] expW [NW], input int mode, input bit disturb);
    int guard;
    int lockDelay;
    int sinceLast;
    bit disturbed;
    guard = 0;
    sinceLast = 0;
    disturbed = 0;
    lockDelay = 2 + int'($urandom_range(GAP + TMO - 20));
    @(negedge clk);
    for (int k = 0; k < NW; k++) wordsIn[k*WW +: WW] = expW[k];
    lockDetect = (mode == 0);
    repeat (4) @(negedge clk);
    nGot = 0; bitsIn = 0; doneCnt = 0; gapPending = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy, "R6 busy after start", busy, 1);
    chk(!locked && !timedOut, "R10 flags cleared at start", {locked, timedOut}, 0);
    while (doneCnt == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (disturb && !disturbed && nGot >= 2) begin
        wordsIn = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        start = 1'b1;
        disturbed = 1;
      end else begin
        start = 1'b0;
      end
      if (mode == 1 && nGot == NW) begin
        sinceLast++;
        if (sinceLast == lockDelay) lockDetect = 1'b1;
      end
    end
    start = 1'b0;
    chk(nGot == NW, "R6 word count", nGot, NW);
    for (int i = 0; i < NW; i++) begin
      chk(got[i] == expW[NW-1-i], "R3 R7 word value", got[i], expW[NW-1-i]);
      chk(got[i][2:0] == 3'(NW-1-i), "R3 address order", got[i][2:0], NW-1-i);
    end
    if (mode == 2) begin
      chk(doneCyc - lastLatchFall == GAP + TMO, "R9 timeout distance", doneCyc - lastLatchFall, GAP + TMO);
    end
    repeat (5) @(negedge clk);
    #1;
    chk(doneCnt == 1, "R6 R10 single done", doneCnt, 1);
    chk(!busy, "R6 idle after done", busy, 0);
    if (mode == 2) chk(timedOut && !locked, "R9 timeout flags", {locked, timedOut}, 1);
    else           chk(locked && !timedOut, "R8 lock flags", {locked, timedOut}, 2);
    lockDetect = 1'b0;
  endtask

  initial begin
    logic [WW-1:0] w [NW];
    int seedInit;
    seedInit = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    #1;
    chk({serClk, serData, serLatch, busy, done, locked, timedOut} == 7'b0, "R1 in reset",
        {serClk, serData, serLatch, busy, done, locked, timedOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk({serClk, serData, serLatch, busy, done, locked, timedOut} == 7'b0, "R1 after reset",
        {serClk, serData, serLatch, busy, done, locked, timedOut}, 0);

    for (int k = 0; k < NW; k++) w[k] = mkWord('0, k);
    runSeq(w, 0, 0);
    for (int k = 0; k < NW; k++) w[k] = mkWord('1, k);
    runSeq(w, 2, 0);
    for (int k = 0; k < NW; k++) w[k] = mkWord(32'hAAAA_AAAA, k);
    runSeq(w, 1, 1);
    for (int k = 0; k < NW; k++) w[k] = mkWord(32'h8000_0001 << k, k);
    runSeq(w, 2, 1);

    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < NW; k++) w[k] = mkWord($urandom(), k);
      runSeq(w, int'($urandom_range(2)), r[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule